// File: doc/BRIEF.md
# JTAG Debug Port Access Responder

This block is the target-side scan-register logic of a JTAG debug port. An external TAP controller supplies the current 4-bit instruction and one-cycle capture, shift and update strobes, all synchronous to the block clock. The block returns serial data on `tdo`. The instruction picks one of four chains: a 35-bit access chain for debug-port registers, the same 35-bit chain for access-port registers, a 35-bit abort chain, and a 32-bit identification chain. Every other code selects a 1-bit bypass chain.

An access scan carries a 3-bit header followed by 32 data bits. On capture, the header slots return an acknowledge, and the data slots return the read value posted by an earlier read. On update, the request is carried out:
- Debug-port requests act on the local control/status and bank-select registers.
- Access-port requests go out as one transaction on a valid/ready internal bus.
- While that transaction is outstanding, any access scan is answered with WAIT and its request is dropped.
- Sticky overrun and error flags block new access-port traffic until software clears them.

Top module: `dbgPortResp`

## Requirements
- R1: Instruction 4'hE selects a 32-bit chain that captures the parameter `ID_VALUE`. Codes other than 4'h8, 4'hA, 4'hB and 4'hE select a 1-bit chain that captures 0 and delays `tdi` by one shift.
- R2: Instructions 4'h8, 4'hA and 4'hB select a 35-bit chain, shifted LSB first. Bit 0 is the read flag (1 = read) and bits [2:1] are the register address A[3:2]; bits [34:3] are data. When no bus transaction is outstanding at capture, bits [2:0] capture 3'b010.
- R3: Bits [34:3] capture the posted read value. A debug-port read of address 1 (control/status), 2 (select) or 0 (reads zero) posts that register at update. A read of address 3 returns the posted value and changes nothing.
- R4: When a bus transaction is outstanding at capture, an access scan captures 3'b001 (WAIT). The request shifted in during that scan is discarded. A bus request holds its address, direction and data until `busReady`.
- R5: A WAIT answer on a debug-port or access-port scan sets sticky overrun (control/status bit 1), but only when overrun detect (bit 0) is 1.
- R6: While sticky overrun or sticky error is set, access-port requests raise no bus request.
- R7: A completed bus transfer with `busErr` set raises sticky error (control/status bit 5). A completed read posts `busRdata`.
- R8: A debug-port write to control/status loads bit 0. It clears bit 1 and/or bit 5 where the written bit is 1, and leaves them unchanged where it is 0.
- R9: Control/status bits [31:28] reflect `pwrUp` at the time of the read.
- R10: An access-port request drives `busAddr` = {select[7:4], A[3:2], 2'b00}. Select bits [7:4] are written by a debug-port write to address 2.
- R11: An abort-chain update with data value 1 cancels an outstanding bus transaction. Any other data value has no effect.
- R12: After reset the block has no bus request, and overrun detect, both sticky flags and the bank are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irValue | input | 4 | Current instruction from the TAP controller |
| captureDr | input | 1 | Capture strobe for the selected chain |
| shiftDr | input | 1 | Shift strobe, one bit per cycle |
| updateDr | input | 1 | Update strobe for the selected chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the chain) |
| pwrUp | input | 4 | Power status of the debug regions |
| busValid | output | 1 | Access-port bus request valid |
| busWrite | output | 1 | Request is a write |
| busAddr | output | 8 | Request address: bank, A[3:2], 2'b00 |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Bus accepts and completes the request |
| busRdata | input | 32 | Read data, valid with busReady |
| busErr | input | 1 | Error response, valid with busReady |

## Verification
The hardest situation to reach is a scan whose capture lands while a bus transaction is still outstanding. This is needed for WAIT, for the overrun flag and for abort. The bench gives its bus responder an adjustable latency. A short latency lets normal reads complete between scans. A latency of 200 cycles keeps a request open across several complete scans, so the bench can issue WAIT-answered reads and writes, a non-one abort and a real abort within that window. The sticky-error path is reached by arming the responder to return an error on its next completion.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam logic [3:0] IR_ABORT = 4'h8;
  localparam logic [3:0] IR_DPACC = 4'hA;
  localparam logic [3:0] IR_APACC = 4'hB;
  localparam logic [3:0] IR_IDENT = 4'hE;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam int HDR_W       = 3;
  localparam int ORUN_EN_BIT = 0;
  localparam int ORUN_BIT    = 1;
  localparam int ERR_BIT     = 5;

  typedef enum logic [1:0] {CH_BYP, CH_ACC, CH_ID} chain_e;

  typedef struct packed {
    logic   capAcc;
    logic   capId;
    logic   capByp;
    logic   shiftEn;
    chain_e chain;
    logic   updDp;
    logic   updAp;
    logic   updAbort;
    logic   waited;
  } strobe_t;
endpackage

// File: rtl/dbgpCtrl.sv
module dbgpCtrl
  import dbgp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] irValue,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  input  logic       busBusy,
  output strobe_t    stb
);
  logic isAcc, isId, isReq, waitFlag;

  assign isAcc = (irValue == IR_ABORT) || (irValue == IR_DPACC) || (irValue == IR_APACC);
  assign isId  = (irValue == IR_IDENT);
  assign isReq = (irValue == IR_DPACC) || (irValue == IR_APACC);

  // WAIT decision is frozen at capture and applied at the matching update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitFlag <= 1'b0;
    else if (captureDr && isReq) waitFlag <= busBusy;
  end

  always_comb begin
    stb.capAcc   = captureDr && isAcc;
    stb.capId    = captureDr && isId;
    stb.capByp   = captureDr && !isAcc && !isId;
    stb.shiftEn  = shiftDr;
    stb.chain    = isAcc ? CH_ACC : (isId ? CH_ID : CH_BYP);
    stb.updDp    = updateDr && (irValue == IR_DPACC);
    stb.updAp    = updateDr && (irValue == IR_APACC);
    stb.updAbort = updateDr && (irValue == IR_ABORT);
    stb.waited   = waitFlag;
  end
endmodule

// File: rtl/dbgpData.sv
module dbgpData
  import dbgp_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          BANK_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h3F2C_5A01,
  localparam int         SCAN_W   = DATA_W + HDR_W,
  localparam int         ADDR_W   = BANK_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              tdi,
  output logic              tdo,
  input  logic [3:0]        pwrUp,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busErr
);
  logic [SCAN_W-1:0] shiftReg;
  logic [DATA_W-1:0] rdPosted, ctrlValue, selValue, wdata;
  logic              orunDet, stickyOrun, stickyErr, hdrRnw;
  logic [BANK_W-1:0] bank;
  logic [1:0]        hdrAddr;

  assign tdo     = shiftReg[0];
  assign hdrRnw  = shiftReg[0];
  assign hdrAddr = shiftReg[2:1];
  assign wdata   = shiftReg[SCAN_W-1:HDR_W];

  always_comb begin
    ctrlValue = '0;
    ctrlValue[DATA_W-1 -: 4]  = pwrUp;
    ctrlValue[ORUN_EN_BIT]    = orunDet;
    ctrlValue[ORUN_BIT]       = stickyOrun;
    ctrlValue[ERR_BIT]        = stickyErr;
    selValue = '0;
    selValue[4 +: BANK_W]     = bank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      rdPosted   <= '0;
      orunDet    <= 1'b0;
      stickyOrun <= 1'b0;
      stickyErr  <= 1'b0;
      bank       <= '0;
      busValid   <= 1'b0;
      busWrite   <= 1'b0;
      busAddr    <= '0;
      busWdata   <= '0;
    end else begin
      // scan register
      if (stb.capAcc)
        shiftReg <= {rdPosted, (busValid ? ACK_WAIT : ACK_OK)};
      else if (stb.capId)
        shiftReg <= {{(SCAN_W-32){1'b0}}, ID_VALUE};
      else if (stb.capByp)
        shiftReg <= '0;
      else if (stb.shiftEn) begin
        case (stb.chain)
          CH_ACC:  shiftReg <= {tdi, shiftReg[SCAN_W-1:1]};
          CH_ID:   shiftReg[31:0] <= {tdi, shiftReg[31:1]};
          default: shiftReg[0] <= tdi;
        endcase
      end

      // bus completion
      if (busValid && busReady) begin
        busValid <= 1'b0;
        if (!busWrite) rdPosted <= busRdata;
        if (busErr) stickyErr <= 1'b1;
      end

      // update of access chains
      if ((stb.updDp || stb.updAp) && stb.waited) begin
        if (orunDet) stickyOrun <= 1'b1;
      end else if (stb.updDp) begin
        if (hdrRnw) begin
          case (hdrAddr)
            2'd0:    rdPosted <= '0;
            2'd1:    rdPosted <= ctrlValue;
            2'd2:    rdPosted <= selValue;
            default: ;
          endcase
        end else begin
          case (hdrAddr)
            2'd1: begin
              orunDet <= wdata[ORUN_EN_BIT];
              if (wdata[ORUN_BIT]) stickyOrun <= 1'b0;
              if (wdata[ERR_BIT])  stickyErr  <= 1'b0;
            end
            2'd2:    bank <= wdata[4 +: BANK_W];
            default: ;
          endcase
        end
      end else if (stb.updAp && !(stickyOrun || stickyErr)) begin
        busValid <= 1'b1;
        busWrite <= !hdrRnw;
        busAddr  <= {bank, hdrAddr, 2'b00};
        busWdata <= wdata;
      end

      if (stb.updAbort && (wdata == DATA_W'(1))) busValid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgPortResp.sv
module dbgPortResp
  import dbgp_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          BANK_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h3F2C_5A01,
  localparam int         ADDR_W   = BANK_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        irValue,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  input  logic [3:0]        pwrUp,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busErr
);
  strobe_t stb;

  dbgpCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .busBusy(busValid), .stb(stb)
  );

  dbgpData #(.DATA_W(DATA_W), .BANK_W(BANK_W), .ID_VALUE(ID_VALUE)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .tdi(tdi), .tdo(tdo), .pwrUp(pwrUp),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata), .busErr(busErr)
  );
endmodule

// File: rtl/dbgPortResp_chk.sv
module dbgPortResp_chk
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 4,
  localparam int ADDR_W = BANK_W + 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        irValue,
  input logic              updateDr,
  input logic              tdo,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busReady
);
  // R4: an open request stays up until accepted (only an update may cancel it)
  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady && !updateDr |=> busValid);

  // R4: request fields are frozen while waiting for ready
  a_r4_stable_fields: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> $stable(busAddr) && $stable(busWrite) && $stable(busWdata));

  // R10: low address bits are always zero
  a_r10_addr_align: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busAddr[1:0] == 2'b00);

  // R6: a new request only follows an access-port update
  a_r6_req_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> $past(updateDr) && ($past(irValue) == IR_APACC));

  // R2: serial output is never unknown
  a_r2_tdo_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(tdo));
endmodule

bind dbgPortResp dbgPortResp_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) chk_i (.*);

// File: tb/dbgPortResp_tb_top.sv
module dbgPortResp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h3F2C_5A01;

  logic clk = 0, rstN = 0;
  logic [3:0] irValue = 4'hF;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, tdi = 0, tdo;
  logic [3:0] pwrUp = 4'hF;
  logic busValid, busWrite, busReady = 0, busErr = 0;
  logic [7:0] busAddr;
  logic [31:0] busWdata, busRdata = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit mOrunDet = 0, mSOrun = 0, mSErr = 0, mPend = 0, mPWrite = 0;
  logic [3:0] mBank = 0;
  logic [31:0] mPosted = 0, mPData = 0;
  logic [7:0] mPAddr = 0;
  int lat = 3, cnt = 0;
  bit errNext = 0, busChk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgPortResp #(.ID_VALUE(ID)) dut_i (
    .clk(clk), .rstN(rstN), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .pwrUp(pwrUp),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .busErr(busErr)
  );

  function automatic logic [31:0] rdataFor(input logic [7:0] a);
    return {16'hC0DE, 8'h00, a};
  endfunction

  function automatic logic [34:0] req(input bit rnw, input logic [1:0] a, input logic [31:0] d);
    return {d, a, rnw};
  endfunction

  function automatic logic [31:0] ctrlModel();
    logic [31:0] v = '0;
    v[31:28] = pwrUp; v[0] = mOrunDet; v[1] = mSOrun; v[5] = mSErr;
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder and per-clock bus comparison (R4 R6 R7 R10 R11)
  always begin
    @(posedge clk); #1;
    if (rstN) begin
      if (busReady) begin
        busReady = 0;
        if (!mPWrite) mPosted = rdataFor(mPAddr);
        if (busErr) mSErr = 1;
        busErr = 0; mPend = 0; cnt = 0;
      end else if (busValid) begin
        cnt++;
        if (cnt >= lat) begin
          busReady = 1; busRdata = rdataFor(busAddr); busErr = errNext; errNext = 0;
        end
      end else cnt = 0;
      if (busChk) begin
        checks++;
        if (busValid !== mPend || (mPend && ({busAddr, busWrite, busWdata} !== {mPAddr, mPWrite, mPData}))) begin
          fails++;
          $display("FAIL R4 R6 R10 R11 bus actual=%b/%h/%b/%h expected=%b/%h/%b/%h",
                   busValid, busAddr, busWrite, busWdata, mPend, mPAddr, mPWrite, mPData);
        end
      end
    end
  end

  // one scan: capture, shift len bits comparing tdo, update; model updated at update
  task automatic scan(input string tag, input logic [3:0] ir, input logic [34:0] din);
    int len;
    bit acc, w;
    logic [34:0] exp, act, mask;
    acc = (ir == 4'h8) || (ir == 4'hA) || (ir == 4'hB);
    len = acc ? 35 : ((ir == 4'hE) ? 32 : 1);
    w = mPend;
    exp = acc ? {mPosted, (w ? 3'b001 : 3'b010)} : ((ir == 4'hE) ? {3'b0, ID} : '0);
    mask = (acc && w) ? 35'h7 : '1;
    act = '0;
    @(negedge clk); irValue = ir; captureDr = 1;
    @(negedge clk); captureDr = 0;
    for (int i = 0; i < len; i++) begin
      act[i] = tdo; tdi = din[i]; shiftDr = 1;
      @(negedge clk);
    end
    shiftDr = 0; updateDr = 1;
    if (acc && ir != 4'h8 && w) begin
      if (mOrunDet) mSOrun = 1;
    end else if (ir == 4'hA) begin
      if (din[0]) begin
        case (din[2:1])
          2'd0: mPosted = 0;
          2'd1: mPosted = ctrlModel();
          2'd2: mPosted = {24'b0, mBank, 4'b0};
          default: ;
        endcase
      end else if (din[2:1] == 2'd1) begin
        mOrunDet = din[3];
        if (din[4]) mSOrun = 0;
        if (din[8]) mSErr = 0;
      end else if (din[2:1] == 2'd2) mBank = din[10:7];
    end else if (ir == 4'hB) begin
      if (!(mSOrun || mSErr)) begin
        mPend = 1; mPWrite = !din[0]; mPAddr = {mBank, din[2:1], 2'b00}; mPData = din[34:3];
      end
    end else if (ir == 4'h8) begin
      if (din[34:3] == 32'd1) mPend = 0;
    end
    @(negedge clk); updateDr = 0;
    check(tag, 64'(act & mask), 64'(exp & mask));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12 reset bus idle", 64'(busValid), 64'(0));
    busChk = 1;
    // R12 / R9: control/status reset value read and posted
    scan("R12 dp read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R12 R9 rdbuff ctrl", 4'hA, req(1, 2'd3, 0));
    // R1: identification and bypass
    scan("R1 ident", 4'hE, 35'h5);
    scan("R1 bypass", 4'h3, 35'h1);
    scan("R1 bypass other", 4'h0, 35'h0);
    // R2 R8: enable overrun detect
    scan("R2 R8 ctrl write", 4'hA, req(0, 2'd1, 32'h1));
    scan("R8 read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R3 rdbuff", 4'hA, req(1, 2'd3, 0));
    scan("R3 rdbuff again", 4'hA, req(1, 2'd3, 0));
    scan("R3 addr0 reads zero", 4'hA, req(1, 2'd0, 0));
    scan("R3 rdbuff zero", 4'hA, req(1, 2'd3, 0));
    // R10: bank select then access-port read
    scan("R10 select write", 4'hA, req(0, 2'd2, 32'h0000_0050));
    scan("R10 select read", 4'hA, req(1, 2'd2, 0));
    scan("R10 ap read", 4'hB, req(1, 2'd1, 0));
    idle(10);
    scan("R7 posted ap data", 4'hA, req(1, 2'd3, 0));
    scan("R10 ap write", 4'hB, req(0, 2'd2, 32'hDEAD_0001));
    idle(10);
    // R4 R5: long transaction, WAIT answers
    lat = 200;
    scan("R4 ap read long", 4'hB, req(1, 2'd3, 0));
    scan("R4 R5 dp read waits", 4'hA, req(1, 2'd1, 0));
    scan("R4 ap write waits", 4'hB, req(0, 2'd0, 32'h1234_5678));
    scan("R4 dp write discarded", 4'hA, req(0, 2'd2, 32'h0000_00A0));
    scan("R11 abort non-one", 4'h8, req(0, 2'd0, 32'h2));
    scan("R11 abort one", 4'h8, req(0, 2'd0, 32'h1));
    idle(3);
    scan("R5 read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R5 R4 sticky orun bank kept", 4'hA, req(1, 2'd2, 0));
    scan("R5 rdbuff select", 4'hA, req(1, 2'd3, 0));
    lat = 3;
    scan("R6 ap read gated", 4'hB, req(1, 2'd1, 0));
    idle(8);
    scan("R8 clear orun", 4'hA, req(0, 2'd1, 32'h3));
    scan("R8 read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R8 rdbuff", 4'hA, req(1, 2'd3, 0));
    // R7: error response
    errNext = 1;
    scan("R7 ap write err", 4'hB, req(0, 2'd1, 32'hCAFE_F00D));
    idle(10);
    scan("R7 read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R6 ap gated by err", 4'hB, req(0, 2'd1, 32'h1));
    idle(8);
    scan("R8 write zero keeps err", 4'hA, req(0, 2'd1, 32'h1));
    scan("R8 read ctrl err kept", 4'hA, req(1, 2'd1, 0));
    scan("R8 clear err", 4'hA, req(0, 2'd1, 32'h20));
    scan("R8 read ctrl err clear", 4'hA, req(1, 2'd1, 0));
    scan("R8 rdbuff", 4'hA, req(1, 2'd3, 0));
    // R5: detect disabled, WAIT does not set overrun
    lat = 200;
    scan("R5 ap read long", 4'hB, req(1, 2'd0, 0));
    scan("R5 wait no detect", 4'hA, req(1, 2'd1, 0));
    scan("R11 abort", 4'h8, req(0, 2'd0, 32'h1));
    lat = 3;
    // R9: power bits follow input
    pwrUp = 4'b1010;
    scan("R9 read ctrl", 4'hA, req(1, 2'd1, 0));
    scan("R9 rdbuff", 4'hA, req(1, 2'd3, 0));
    scan("R10 ap read after", 4'hB, req(1, 2'd2, 0));
    idle(10);
    scan("R7 rdbuff ap", 4'hA, req(1, 2'd3, 0));
    busChk = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule